// File: doc/BRIEF.md
# Oscillator Stop Flag Register

This block holds a sticky status bit that tells software whether the timekeeping oscillator has stopped at any point since the flag was last cleared. Software uses the bit to decide whether the stored time and date can be trusted. The block sees an asynchronous oscillator-running indication and the oscillator-disable control bit. A run-to-stop transition on either one sets the flag. A stop caused by a collapsing supply reaches the block through the same running indication.

Power-on reset forces the flag to one, because time is never valid after first power-up. Software reads the register as one byte. The flag sits in the top bit and the other bits always read zero. Software can clear the flag by writing zero to it. Writing one to it does nothing. A stop event in the same cycle as a clear wins over the clear.

Top module: `osc_stop_flag`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rd_data_o` reads 8'h80, with the flag in bit 7.
- R2: A fall of `osc_running_i` sets the flag. The input passes through a two-flop synchronizer, so the flag shows on `rd_data_o[7]` after the third rising edge following the fall, and not earlier.
- R3: A stopped level alone never sets the flag. After a clear made while the oscillator is already stopped, the flag stays zero.
- R4: Raising `osc_disable_i` while the synchronized running indication is high sets the flag at the next rising edge.
- R5: A cycle with `wr_en_i` high and `wr_data_i[7]` low clears the flag at the next edge.
- R6: Writing one to bit 7 leaves the flag unchanged, whether it is zero or one.
- R7: Bits 6:0 of `rd_data_o` read zero at all times, and writes to those bits have no effect.
- R8: When a stop event and a clear write fall in the same cycle, the flag ends at one.
- R9: With `wr_en_i` low, `wr_data_i` has no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low power-on reset |
| osc_running_i | input | 1 | Asynchronous oscillator-running indication |
| osc_disable_i | input | 1 | Oscillator-disable control bit, synchronous to clk |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read value |

## Verification
A wrong edge-detector state shows up on `rd_data_o[7]` as a flag that rises one or more cycles off the expected synchronizer latency, or that rises on a steady stopped level. Both are visible within three edges of the stimulus. A lost set/clear priority, or a flag that drops on writes of one, shows at the very next read. The clear-while-stopped case also exposes an edge detector that has collapsed into a level detector.

// File: rtl/osc_stop_flag.sv
module osc_stop_flag #(
  parameter int DATA_W      = 8,
  parameter int FLAG_BIT    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_running_i,
  input  logic              osc_disable_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   run_now;
  logic                   run_prev;
  logic                   stop_evt;
  logic                   clr_req;
  logic                   flag_q;
  logic                   unused_wr_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], osc_running_i};
  end

  assign run_now  = sync_q[SYNC_STAGES-1] & ~osc_disable_i;
  assign stop_evt = run_prev & ~run_now;
  assign clr_req  = wr_en_i & ~wr_data_i[FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_prev <= 1'b0;
      flag_q   <= 1'b1;
    end else begin
      run_prev <= run_now;
      if (stop_evt)     flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data_o           = '0;
    rd_data_o[FLAG_BIT] = flag_q;
  end

  assign unused_wr_bits = ^{wr_data_i[FLAG_BIT-1:0], 1'b0};

endmodule

module osc_stop_flag_chk #(
  parameter int DATA_W   = 8,
  parameter int FLAG_BIT = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              run_prev,
  input logic              run_now
);

  logic clr_w;
  logic set_w;
  assign clr_w = wr_en_i && !wr_data_i[FLAG_BIT];
  assign set_w = run_prev && !run_now;

  p_rise_needs_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data_o[FLAG_BIT]) |-> $past(set_w));

  p_clear_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && !set_w) |=> !rd_data_o[FLAG_BIT]);

  p_one_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[FLAG_BIT] && !clr_w) |=> rd_data_o[FLAG_BIT]);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_w |=> rd_data_o[FLAG_BIT]);

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !set_w) |=> $stable(rd_data_o[FLAG_BIT]));

  p_low_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (rd_data_o[FLAG_BIT-1:0] == '0));

endmodule

bind osc_stop_flag osc_stop_flag_chk #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o), .run_prev(run_prev), .run_now(run_now)
);

// File: tb/osc_stop_flag_bench.sv
module osc_stop_flag_bench;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_running = 1'b0;
  logic       osc_disable = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;

  item_t q[$];
  int    tests = 0;
  int    fails = 0;
  bit    done  = 1'b0;

  always #2 clk = ~clk;

  osc_stop_flag u_osc_stop_flag (
    .clk(clk), .rst_n(rst_n), .osc_running_i(osc_running),
    .osc_disable_i(osc_disable), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data)
  );

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      tests++;
      if (rd_data !== it.exp) begin
        fails++;
        $display("FAIL %s: rd_data=%h expected=%h", it.tag, rd_data, it.exp);
      end
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_rd(input logic [7:0] exp, input string tag);
    q.push_back('{exp, tag});
  endtask

  task automatic write_reg(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  initial begin
    step(3);
    expect_rd(8'h80, "R1 during reset");
    step();
    rst_n = 1'b1;
    step();
    expect_rd(8'h80, "R1 after reset");
    step();

    osc_running = 1'b1;
    step(4);
    expect_rd(8'h80, "R6 flag held while running");
    write_reg(8'hFF);
    expect_rd(8'h80, "R6/R7 write ones keeps flag, low bits zero");
    step();
    write_reg(8'h7F);
    expect_rd(8'h00, "R5 clear by writing zero");
    step();
    write_reg(8'h80);
    expect_rd(8'h00, "R6 write one to cleared flag");
    step();
    write_reg(8'h7F);
    expect_rd(8'h00, "R7 low bits ignore writes");
    step();

    osc_running = 1'b0;
    step();
    expect_rd(8'h00, "R2 not after one edge");
    step();
    expect_rd(8'h00, "R2 not after two edges");
    step();
    expect_rd(8'h80, "R2 set after three edges");
    step();

    write_reg(8'h00);
    expect_rd(8'h00, "R5 clear while stopped");
    step(5);
    expect_rd(8'h00, "R3 stopped level does not set");
    step();

    osc_running = 1'b1;
    step(4);
    osc_disable = 1'b1;
    step();
    expect_rd(8'h80, "R4 disable sets flag");
    step();
    wr_en = 1'b0; wr_data = 8'h00;
    step(3);
    expect_rd(8'h80, "R9 data without strobe ignored");
    step();
    write_reg(8'h00);
    expect_rd(8'h00, "R3 clear while disabled sticks");
    step(3);
    expect_rd(8'h00, "R3 disabled level does not set");
    step();

    osc_disable = 1'b0;
    step(2);
    osc_disable = 1'b1;
    wr_en = 1'b1; wr_data = 8'h00;
    step();
    wr_en = 1'b0;
    expect_rd(8'h80, "R8 set wins over clear");
    step();
    osc_disable = 1'b0;
    step(2);
    expect_rd(8'h80, "R6 flag holds after restart");
    step(2);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: rd_data=%h expected=completion", rd_data);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule